// File: doc/BRIEF.md
# Bit-Slip Deserializer with Word Realignment

This block turns a serial bit stream into parallel words. A fast bit clock shifts each incoming bit into a shift register. A modulo-N counter on the same clock fires a load strobe once per word, which copies the newest N bits into a parallel word register that the slow word-clock domain reads. The fast clock runs at exactly N times the slow clock, and the two clocks are phase-aligned.

Logic in the slow domain moves the word boundary by raising an align request. The request counts only when it is sampled high on two slow edges in a row. Each counted request is passed into the fast domain through a two-flop synchronizer. There it holds the load counter for one fast cycle. That load interval becomes N+1 bits long, and from then on every word is framed one bit later. The data path is never barrel-shifted. A request held high produces a single slip, and the slip count wraps modulo N.

Top module: `bitslip_deser`

## Requirements
- R1: While `rstN` is low, `wordOut` is 0, `wordValid` is 0 and `slipCount` is 0.
- R2: With no slip pending, `wordValid` pulses for exactly one fast cycle every N fast cycles. During the pulse `wordOut` holds the last N bits sampled on `serialIn`: bit N-1 is the oldest and bit 0 is the newest.
- R3: Between `wordValid` pulses, `wordOut` does not change.
- R4: An align request that is sampled high on only one slow edge causes no slip, and the word boundary stays where it was.
- R5: An align request sampled high on two consecutive slow edges causes exactly one slip. One load interval lasts N+1 fast cycles, and the boundary then moves one bit later.
- R6: An align request held high for many slow cycles causes only one slip. A further slip needs the request to be sampled low and then qualified again.
- R7: The word loaded at the end of the stretched interval is still presented. It holds the newest N bits, and no word pulse is dropped.
- R8: `slipCount` adds one, modulo N, for each slip. After N slips the boundary is back at its original position and `slipCount` reads 0.
- R9: A reset during operation restores the default boundary, with the first word complete N fast cycles after release, and clears `slipCount`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkFast | input | 1 | Bit clock, N times the word clock, phase-aligned with it |
| clkSlow | input | 1 | Word clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| serialIn | input | 1 | Serial data, sampled on the rising edge of clkFast |
| alignReq | input | 1 | Boundary slip request, driven in the clkSlow domain |
| wordOut | output | N | Parallel word, newest bit at bit 0 |
| wordValid | output | 1 | One-fast-cycle pulse marking a newly loaded word |
| slipCount | output | $clog2(N) | Number of slips taken, modulo N |

## Verification
The assertions assume that `alignReq` changes only with respect to `clkSlow` and that every rising edge of `clkSlow` coincides with a rising edge of `clkFast`. The stimulus guarantees this by generating both clocks from one time base and by changing `alignReq` only on falling edges of `clkSlow`. The assertions also assume that `serialIn` is stable around each fast edge. The stimulus guarantees this by changing `serialIn` only on falling edges of `clkFast`.

// File: rtl/deser_pkg.sv
`timescale 1ns/1ps
package deser_pkg;
  // strobes from control to datapath, both in the fast domain
  typedef struct packed {
    logic load;   // copy the assembled word this edge
    logic slip;   // one slip accepted this edge
  } strobe_t;
endpackage

// File: rtl/deser_ctrl.sv
`timescale 1ns/1ps
module deser_ctrl
  import deser_pkg::*;
#(
  parameter int N = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clkFast,
  input  logic    clkSlow,
  input  logic    rstN,
  input  logic    alignReq,
  output strobe_t strb
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  // slow domain: qualification over two consecutive word edges
  logic reqPrev, armed, slipToggle, accept;

  assign accept = alignReq && reqPrev && armed;

  always_ff @(posedge clkSlow or negedge rstN) begin
    if (!rstN) begin
      reqPrev    <= 1'b0;
      armed      <= 1'b1;
      slipToggle <= 1'b0;
    end else begin
      reqPrev <= alignReq;
      if (!alignReq)   armed <= 1'b1;
      else if (accept) armed <= 1'b0;
      if (accept) slipToggle <= ~slipToggle;
    end
  end

  // fast domain: toggle synchronizer plus one edge-detect stage
  logic [SYNC_STAGES:0] syncReg;
  logic slipStb, loadStb;
  logic [CW-1:0] cnt;

  always_ff @(posedge clkFast or negedge rstN) begin
    if (!rstN) syncReg <= '0;
    else       syncReg <= {syncReg[SYNC_STAGES-1:0], slipToggle};
  end

  assign slipStb = syncReg[SYNC_STAGES] ^ syncReg[SYNC_STAGES-1];
  assign loadStb = (cnt == LAST) && !slipStb;

  // load counter; a slip holds it for one bit period
  always_ff @(posedge clkFast or negedge rstN) begin
    if (!rstN)         cnt <= '0;
    else if (slipStb)  cnt <= cnt;
    else if (cnt == LAST) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign strb.load = loadStb;
  assign strb.slip = slipStb;

  AST_ACCEPT_ONCE: assert property (@(posedge clkSlow) disable iff (!rstN)
    accept |=> !accept) else $error("second accept without release"); // R6

  AST_SLIP_ONESHOT: assert property (@(posedge clkFast) disable iff (!rstN)
    slipStb |=> !slipStb) else $error("slip strobe longer than one cycle"); // R5

  AST_SLIP_STRETCH: assert property (@(posedge clkFast) disable iff (!rstN)
    (cnt == LAST && slipStb) |=> loadStb) else $error("delayed load missing"); // R5

  initial begin
    if (N < 2) $error("N must be at least 2");
    if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
  end
endmodule

// File: rtl/deser_datapath.sv
`timescale 1ns/1ps
module deser_datapath
  import deser_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                 clkFast,
  input  logic                 rstN,
  input  logic                 serialIn,
  input  strobe_t              strb,
  output logic [N-1:0]         wordOut,
  output logic                 wordValid,
  output logic [$clog2(N)-1:0] slipCount
);
  localparam int SW = $clog2(N);
  localparam logic [SW-1:0] LASTSLIP = SW'(N - 1);

  logic [N-2:0] shiftReg;
  logic [N-1:0] newWord;

  assign newWord = {shiftReg, serialIn};

  always_ff @(posedge clkFast or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      shiftReg  <= newWord[N-2:0];
      wordValid <= strb.load;
      if (strb.load) wordOut <= newWord;
    end
  end

  always_ff @(posedge clkFast or negedge rstN) begin
    if (!rstN)          slipCount <= '0;
    else if (strb.slip) slipCount <= (slipCount == LASTSLIP) ? '0 : slipCount + 1'b1;
  end

  AST_VALID_PULSE: assert property (@(posedge clkFast) disable iff (!rstN)
    wordValid |=> !wordValid) else $error("word pulses too close"); // R2

  AST_WORD_HOLD: assert property (@(posedge clkFast) disable iff (!rstN)
    !wordValid |-> $stable(wordOut)) else $error("word changed without pulse"); // R3

  AST_SLIP_COUNT: assert property (@(posedge clkFast) disable iff (!rstN)
    strb.slip |=> slipCount != $past(slipCount)) else $error("slip not counted"); // R8
endmodule

// File: rtl/bitslip_deser.sv
`timescale 1ns/1ps
module bitslip_deser
  import deser_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                 clkFast,
  input  logic                 clkSlow,
  input  logic                 rstN,
  input  logic                 serialIn,
  input  logic                 alignReq,
  output logic [N-1:0]         wordOut,
  output logic                 wordValid,
  output logic [$clog2(N)-1:0] slipCount
);
  strobe_t strb;

  deser_ctrl #(.N(N), .SYNC_STAGES(2)) ctrl_i (
    .clkFast (clkFast),
    .clkSlow (clkSlow),
    .rstN    (rstN),
    .alignReq(alignReq),
    .strb    (strb)
  );

  deser_datapath #(.N(N)) dp_i (
    .clkFast  (clkFast),
    .rstN     (rstN),
    .serialIn (serialIn),
    .strb     (strb),
    .wordOut  (wordOut),
    .wordValid(wordValid),
    .slipCount(slipCount)
  );
endmodule

// File: tb/bitslip_deser_tb_top.sv
`timescale 1ns/1ps
module bitslip_deser_tb_top;
  localparam int N = 8;
  localparam int SW = $clog2(N);

  logic clkFast = 1'b0;
  logic clkSlow = 1'b0;
  logic rstN = 1'b0;
  logic serialIn = 1'b0;
  logic alignReq = 1'b0;
  logic [N-1:0] wordOut;
  logic wordValid;
  logic [SW-1:0] slipCount;

  bitslip_deser #(.N(N)) dut_i (
    .clkFast(clkFast), .clkSlow(clkSlow), .rstN(rstN), .serialIn(serialIn),
    .alignReq(alignReq), .wordOut(wordOut), .wordValid(wordValid), .slipCount(slipCount)
  );

  // 100 MHz bit clock; word clock rises together with every eighth bit edge
  initial forever begin #5 clkFast = 1'b1; #5 clkFast = 1'b0; end
  initial begin #5; forever begin clkSlow = 1'b1; #40; clkSlow = 1'b0; #40; end end

  int nChecks = 0;
  int nFails = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard state
  bit bitQ[$];
  logic [N-1:0] window = '0;
  logic [N-1:0] lastWord = '0;
  int idx = 0;
  int lastOffset = -1;
  logic [15:0] lfsr = 16'hACE1;

  // monitor: the bit the design takes at each rising edge
  always @(posedge clkFast) begin
    if (running) begin
      bit b;
      b = (bitQ.size() > 0) ? bitQ.pop_front() : 1'b0;
      window = {window[N-2:0], b};
      idx++;
    end
  end

  // compare on falling edges, then drive the next bit
  always @(negedge clkFast) begin
    if (running) begin
      bit nb;
      if (wordValid) begin
        check(wordOut == window, "R2 R7 word content", int'(wordOut), int'(window));
        lastOffset = idx % N;
        lastWord = wordOut;
      end else begin
        check(wordOut == lastWord, "R3 word hold", int'(wordOut), int'(lastWord));
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      nb = lfsr[0];
      serialIn = nb;
      bitQ.push_back(nb);
    end
  end

  task automatic slowCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clkSlow);
  endtask

  task automatic alignHold(input int nHigh);
    @(negedge clkSlow);
    alignReq = 1'b1;
    slowCycles(nHigh);
    alignReq = 1'b0;
    slowCycles(4);
  endtask

  task automatic checkPhase(input int slips, input string tag);
    check(lastOffset == slips % N, {tag, " boundary offset"}, lastOffset, slips % N);
    check(int'(slipCount) == slips % N, {tag, " slip count"}, int'(slipCount), slips % N);
  endtask

  task automatic checkResetState(input string tag);
    check(wordOut == '0, {tag, " wordOut"}, int'(wordOut), 0);
    check(wordValid == 1'b0, {tag, " wordValid"}, int'(wordValid), 0);
    check(slipCount == '0, {tag, " slipCount"}, int'(slipCount), 0);
  endtask

  task automatic startRun();
    @(negedge clkFast);
    #2;
    rstN = 1'b1;
    running = 1'b1;
  endtask

  initial begin
    slowCycles(3);
    @(negedge clkFast);
    checkResetState("R1");
    startRun();
    slowCycles(4);
    checkPhase(0, "R2");

    alignHold(1);                 // single sample: ignored
    checkPhase(0, "R4");

    alignHold(2);                 // qualified
    checkPhase(1, "R5");

    alignHold(7);                 // held long: one slip only
    checkPhase(2, "R6");

    for (int k = 3; k <= N; k++) alignHold(2);
    checkPhase(N, "R8 wrap");     // back to original boundary, count 0

    alignHold(3);
    checkPhase(N + 1, "R8 after wrap");

    // reset during operation
    @(negedge clkFast);
    #2;
    running = 1'b0;
    rstN = 1'b0;
    bitQ.delete();
    window = '0;
    lastWord = '0;
    idx = 0;
    lastOffset = -1;
    serialIn = 1'b0;
    slowCycles(2);
    checkResetState("R9 in reset");
    startRun();
    slowCycles(4);
    checkPhase(0, "R9 after release");

    alignHold(2);
    checkPhase(1, "R9 slip after reset");

    running = 1'b0;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #1ms;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule